// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block is the digital heart of a spread-spectrum clock synthesizer. On every reference clock it produces a signed frequency-offset word. The word steers a downstream oscillator, such as a digitally controlled oscillator or a fractional-N divider. The offset follows a fixed symmetric triangle with a period of 1024 reference cycles, which is close to one thousandth of the clock rate. It is expressed in units of 1/65536 of the nominal frequency.

A two-bit code chooses the total peak-to-peak spread. A mode input chooses between two placements of the spread. In center spread the spread is symmetric about nominal. In down spread it lies entirely below nominal, so the output never exceeds the nominal frequency. An active-low enable lets the triangle run. When the enable is high, the offset stays at zero.

All control inputs are captured only at the boundary between two modulation periods, where the offset is zero. A one-cycle pulse marks the start of each period.

Top module: `sscg_profile_gen`

## Requirements
- R1: The spread code selects a peak-to-peak span of 410, 820, 1638 or 2458 counts for codes 00, 01, 10 and 11. These correspond to 0.625%, 1.25%, 2.5% and 3.75% of 65536, each rounded to an even count.
- R2: While the captured enable is inactive (`spread_en_n` high), the offset is zero for the whole period.
- R3: A modulation period is exactly 1024 reference cycles. `period_start` is high for one cycle at its start and low for the other 1023 cycles.
- R4: In center mode (`down_mode` = 0), the offset reaches +span/2 at phase 256 and −span/2 at phase 768, and never leaves that range.
- R5: In down mode (`down_mode` = 1), the offset is never positive. It reaches −span at phase 512.
- R6: After a synchronous reset, the first period uses enabled, code 11 and center mode, whatever the input pins are. During reset the offset is 0 and `period_start` is 1.
- R7: Changes to `spread_en_n`, `spread_code` or `down_mode` are applied only at the start of the next period. A change in mid-period leaves the current waveform unchanged.
- R8: The offset is zero in the cycle in which `period_start` is high.
- R9: The waveform is a linear triangle. The offset changes by at most 5 counts between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spread_en_n | input | 1 | Modulation enable, active low |
| spread_code | input | 2 | Peak-to-peak spread select |
| down_mode | input | 1 | 0 = center spread, 1 = down spread |
| freq_offset | output | 16 | Signed frequency offset, 1/65536 of nominal per count |
| period_start | output | 1 | One-cycle pulse at the start of each period |

## Verification
Two situations are the hardest to reach from the ports. One is a control change that lands in the middle of a period, where the old waveform must continue untouched. The other is a reset taken while the pins disagree with the reset defaults. The stimulus aligns itself to `period_start` and changes the pins at phase 100, then follows both the rest of that period and the next one. It also asserts reset with every pin set opposite to its default, and measures the first period after release.

// File: rtl/sscg_pkg.sv
// Package: shared types and the spread-code decode for the modulation
// profile generator. Assumes a 16-bit offset scaled to 1/65536 of nominal.
package sscg_pkg;

    // Captured control set, applied for one full modulation period.
    typedef struct packed {
        logic       run;   // 1 = triangle active
        logic [1:0] code;  // spread amount select
        logic       down;  // 1 = down spread, 0 = center spread
    } ss_cfg_t;

    // Power-on control set: spreading on, widest code, center placement.
    localparam ss_cfg_t CFG_RESET = '{run: 1'b1, code: 2'b11, down: 1'b0};

    // Peak-to-peak span in offset counts for a spread code.
    // The spread is held in thousandths of a percent; the span is
    // rounded so that it is always even, giving an exact half span.
    function automatic int span_counts(input logic [1:0] code);
        int milli;
        case (code)
            2'b00:   milli = 625;
            2'b01:   milli = 1250;
            2'b10:   milli = 2500;
            default: milli = 3750;
        endcase
        return 2 * ((milli * 65536 + 100000) / 200000);
    endfunction

endpackage

// File: rtl/sscg_phase.sv
// Module: modulation phase counter. Counts reference cycles modulo
// 2**PER_LOG2 and flags both the first and the last cycle of a period.
// Assumes PER_LOG2 >= 2 so that the two flags never coincide.
module sscg_phase #(
    parameter int PER_LOG2 = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [PER_LOG2-1:0] phase_o,
    output logic                first_o,
    output logic                last_o
);

    logic [PER_LOG2-1:0] ph_q;

    // Free-running phase, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_q + 1'b1;
    end

    assign phase_o = ph_q;
    assign first_o = (ph_q == '0);
    assign last_o  = (ph_q == '1);

    // The start flag is a single-cycle pulse.
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        first_o |=> !first_o);

    // Every last cycle is followed by a start cycle.
    p_wrap_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> first_o);

endmodule

// File: rtl/sscg_cfg_latch.sv
// Module: control capture. Samples the enable, code and mode pins only on
// the last cycle of a period, so that a new setting takes effect exactly
// where the offset is zero. Reset loads the power-on control set.
module sscg_cfg_latch
    import sscg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wrap_i,
    input  logic    en_n_i,
    input  logic [1:0] code_i,
    input  logic    down_i,
    output ss_cfg_t cfg_o
);

    ss_cfg_t cfg_q;

    // Capture the pins at the period boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (wrap_i) cfg_q <= '{run: !en_n_i, code: code_i, down: down_i};
    end

    assign cfg_o = cfg_q;

    // Outside a boundary the captured set never moves.
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap_i) |-> $stable(cfg_o));

endmodule

// File: rtl/sscg_ramp.sv
// Module: triangle accumulator. Adds or subtracts a code-dependent step
// each cycle; the sign is picked from the top phase bits and the mode.
// The fractional width equals PER_LOG2-1, so the step in accumulator units
// equals the span in offset counts and a half period lands exactly on it.
// Assumes the captured control set changes only when the phase wraps.
module sscg_ramp
    import sscg_pkg::*;
#(
    parameter int PER_LOG2 = 10,
    parameter int OFS_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PER_LOG2-1:0]     phase_i,
    input  ss_cfg_t                 cfg_i,
    output logic signed [OFS_W-1:0] offset_o
);

    localparam int FRAC    = PER_LOG2 - 1;
    localparam int ACC_W   = OFS_W + FRAC;
    localparam int QUARTER = 1 << (PER_LOG2 - 2);
    localparam int HALF    = 1 << (PER_LOG2 - 1);
    localparam logic signed [ACC_W-1:0] MAX_STEP = ACC_W'(span_counts(2'b11));

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] step;
    logic signed [OFS_W-1:0] half_span;
    logic                    rising;

    // Step size and direction for the current phase and setting.
    always_comb begin
        step      = ACC_W'(span_counts(cfg_i.code));
        half_span = OFS_W'(span_counts(cfg_i.code) / 2);
        if (cfg_i.down) rising = phase_i[PER_LOG2-1];
        else            rising = (phase_i[PER_LOG2-1] == phase_i[PER_LOG2-2]);
    end

    // Up/down accumulation; held at zero while spreading is off.
    always_ff @(posedge clk) begin
        if (!rst_n)          acc_q <= '0;
        else if (!cfg_i.run) acc_q <= '0;
        else if (rising)     acc_q <= acc_q + step;
        else                 acc_q <= acc_q - step;
    end

    assign offset_o = acc_q[ACC_W-1:FRAC];

    // Zero offset at the start of every period.
    p_zero_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == '0) |-> (acc_q == '0));

    // Disabled spreading keeps the offset at zero.
    p_disabled_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.run |-> (offset_o == '0));

    // Down spread never rises above nominal.
    p_down_nonpos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.run && cfg_i.down) |-> (offset_o == '0 || offset_o[OFS_W-1]));

    // Down spread bottoms out at the full span at mid-period.
    p_down_trough_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.run && cfg_i.down && phase_i == PER_LOG2'(HALF))
        |-> (offset_o == -OFS_W'(span_counts(cfg_i.code))));

    // Center spread stays within plus and minus half the span.
    p_center_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.run && !cfg_i.down)
        |-> (offset_o <= half_span && offset_o >= -half_span));

    // Center spread peaks at the first quarter point.
    p_center_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.run && !cfg_i.down && phase_i == PER_LOG2'(QUARTER))
        |-> (offset_o == half_span));

    // Linear slope: no jump larger than the widest step.
    p_slew_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q - $past(acc_q) <= MAX_STEP) && ($past(acc_q) - acc_q <= MAX_STEP));

endmodule

// File: rtl/sscg_profile_gen.sv
// Module: top of the spread-spectrum modulation profile generator.
// Joins the phase counter, the control capture and the triangle ramp.
// Produces a signed offset word and a period-start pulse. The reset is
// synchronous and active low; all logic runs on the reference clock.
module sscg_profile_gen
    import sscg_pkg::*;
#(
    parameter int PER_LOG2 = 10,
    parameter int OFS_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spread_en_n,
    input  logic [1:0]              spread_code,
    input  logic                    down_mode,
    output logic signed [OFS_W-1:0] freq_offset,
    output logic                    period_start
);

    logic [PER_LOG2-1:0] phase;
    logic                first_cyc;
    logic                last_cyc;
    ss_cfg_t             cfg;

    sscg_phase #(.PER_LOG2(PER_LOG2)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .first_o (first_cyc),
        .last_o  (last_cyc)
    );

    sscg_cfg_latch u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap_i (last_cyc),
        .en_n_i (spread_en_n),
        .code_i (spread_code),
        .down_i (down_mode),
        .cfg_o  (cfg)
    );

    sscg_ramp #(.PER_LOG2(PER_LOG2), .OFS_W(OFS_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase),
        .cfg_i    (cfg),
        .offset_o (freq_offset)
    );

    assign period_start = first_cyc;

endmodule

// File: tb/tb_sscg_profile_gen.sv
// Bench: table-driven sweep of every code and mode, then directed tests
// for reset defaults and a mid-period control change.
module tb_sscg_profile_gen;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spread_en_n = 1'b0;
    logic [1:0]        spread_code = 2'b00;
    logic              down_mode = 1'b0;
    logic signed [15:0] freq_offset;
    logic              period_start;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam int NV = 10;
    localparam int V_EN_N [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
    localparam int V_CODE [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 3, 2};
    localparam int V_DOWN [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 1};
    localparam int V_MAX  [NV] = '{205, 410, 819, 1229, 0, 0, 0, 0, 0, 0};
    localparam int V_MIN  [NV] = '{-205, -410, -819, -1229, -410, -820, -1638, -2458, 0, 0};

    sscg_profile_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .spread_en_n  (spread_en_n),
        .spread_code  (spread_code),
        .down_mode    (down_mode),
        .freq_offset  (freq_offset),
        .period_start (period_start)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected <= 100000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Walk one full period from a negedge where period_start is high.
    // At phase chg_k the pins take the c_* values (chg_k < 0: never).
    task automatic run_period(input int chg_k, input int c_en_n, input int c_code,
                              input int c_down, output int mx, output int mn,
                              output int at_q, output int at_h, output int z0,
                              output int slew, output int stray, output int endp);
        int prev;
        int v;
        int d;
        mx = -99999; mn = 99999; slew = 0; stray = 0; prev = 0;
        at_q = 0; at_h = 0; z0 = 0;
        for (int k = 0; k < 1024; k++) begin
            v = int'(freq_offset);
            if (k == 0) z0 = v;
            if (k == 256) at_q = v;
            if (k == 512) at_h = v;
            if (v > mx) mx = v;
            if (v < mn) mn = v;
            if (k > 0) begin
                d = (v > prev) ? v - prev : prev - v;
                if (d > slew) slew = d;
                if (period_start) stray++;
            end
            prev = v;
            if (k == chg_k) begin
                spread_en_n = c_en_n[0];
                spread_code = c_code[1:0];
                down_mode   = c_down[0];
            end
            @(negedge clk);
        end
        endp = int'(period_start);
    endtask

    task automatic wait_start();
        @(negedge clk);
        while (!period_start) @(negedge clk);
    endtask

    initial begin
        int mx, mn, aq, ah, z0, sl, st, ep;

        // Reset state, pins opposite to the defaults (R6).
        spread_en_n = 1'b1; spread_code = 2'b00; down_mode = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 offset in reset", int'(freq_offset), 0);
        chk("R6 period_start in reset", int'(period_start), 1);
        rst_n = 1'b1;
        run_period(-1, 0, 0, 0, mx, mn, aq, ah, z0, sl, st, ep);
        chk("R6 default max", mx, 1229);
        chk("R6 default min", mn, -1229);
        chk("R3 period length after reset", ep, 1);
        // The pins were captured at that boundary: spreading now off (R2, R7).
        run_period(-1, 0, 0, 0, mx, mn, aq, ah, z0, sl, st, ep);
        chk("R2 disabled max", mx, 0);
        chk("R2 disabled min", mn, 0);

        // Table sweep over codes and modes (R1, R2, R3, R4, R5, R8, R9).
        for (int i = 0; i < NV; i++) begin
            spread_en_n = V_EN_N[i][0];
            spread_code = V_CODE[i][1:0];
            down_mode   = V_DOWN[i][0];
            wait_start();
            run_period(-1, 0, 0, 0, mx, mn, aq, ah, z0, sl, st, ep);
            chk($sformatf("R1 max vec %0d", i), mx, V_MAX[i]);
            chk($sformatf("R1 min vec %0d", i), mn, V_MIN[i]);
            if (V_DOWN[i] != 0)
                chk($sformatf("R5 trough at phase 512 vec %0d", i), ah, V_MIN[i]);
            else
                chk($sformatf("R4 peak at phase 256 vec %0d", i), aq, V_MAX[i]);
            chk($sformatf("R8 zero at start vec %0d", i), z0, 0);
            chk($sformatf("R9 slew within 5 vec %0d", i), (sl <= 5) ? 1 : 0, 1);
            chk($sformatf("R3 no stray pulse vec %0d", i), st, 0);
            chk($sformatf("R3 pulse after 1024 vec %0d", i), ep, 1);
        end

        // Mid-period change (R7): code 00 center, switch to 11 down at phase 100.
        spread_en_n = 1'b0; spread_code = 2'b00; down_mode = 1'b0;
        wait_start();
        run_period(100, 0, 3, 1, mx, mn, aq, ah, z0, sl, st, ep);
        chk("R7 old max kept", mx, 205);
        chk("R7 old min kept", mn, -205);
        run_period(-1, 0, 0, 0, mx, mn, aq, ah, z0, sl, st, ep);
        chk("R7 new max applied", mx, 0);
        chk("R7 new min applied", mn, -2458);

        // Disable in mid-period (R7, R2): current period still spreads.
        spread_code = 2'b01; down_mode = 1'b0;
        wait_start();
        run_period(300, 1, 1, 0, mx, mn, aq, ah, z0, sl, st, ep);
        chk("R7 disable deferred max", mx, 410);
        run_period(-1, 0, 0, 0, mx, mn, aq, ah, z0, sl, st, ep);
        chk("R2 disabled after boundary max", mx, 0);
        chk("R2 disabled after boundary min", mn, 0);
        chk("R3 pulses while disabled", ep, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule